// File: doc/BRIEF.md
# Synthesizer Divider Configuration Loader

This block captures and holds the configuration word that a frequency synthesizer's dividers run from. The word has three fields: a 9-bit feedback divide value, a 2-bit output divide code and a 2-bit test-select field. The word can arrive by either of two paths.

The first path is a set of parallel pins qualified by a parallel-load control, which is active low. The second is a three-wire serial port made of a serial clock, a data line and a load strobe. The load strobe acts on both of its edges. Its rising edge copies the shift register into the active registers. Its falling edge freezes them. While it stays high, the active registers follow every serial shift.

The four serial and load controls are asynchronous to the block. Each passes through a two-flop synchronizer clocked by a fast system clock, which must run at least four times faster than the serial clock. All edges are found by synchronous edge detection. The block drives the active field values and a tap on the shift register, and it drives nothing else.

Top module: `divcfg_loader`

## Requirements
- R1: While the synchronized parallel-load control is low, the active divide and output-code registers take the pin values on every system clock, one cycle after the pins change.
- R2: A rising edge of the parallel-load control captures the pins one final time. Later pin changes are then ignored until that control goes low again.
- R3: While the parallel-load control is high, each rising serial clock edge shifts one data bit into a 13-bit shift register, most significant bit first. The register order from the top bit down is test-select bit 1, test-select bit 0, output code bit 1, output code bit 0, then divide bits 8 down to 0. The shiftTap output shows the bit most recently shifted in.
- R4: A rising edge of the serial load strobe copies the shift register into the active divide, output-code and test-select registers.
- R5: After the serial load strobe falls, the active values stay frozen while further bits are shifted in with the strobe low.
- R6: While the serial load strobe stays high, every rising serial clock edge passes the updated shift contents straight to the active registers.
- R7: With the parallel-load control high, the serial load strobe low and no serial clock edge, none of the active outputs changes.
- R8: Only the serial path writes the test-select register. Parallel captures leave it untouched. The activeT output reads 0 while the synchronized parallel-load control is low, and it shows the held value again once that control is high.
- R9: While reset is asserted, the active divide and output code take the pin values, the test-select field is 0 and the shift register is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rstN | input | 1 | Synchronous power-on reset, active low |
| pinM | input | 9 | Parallel feedback divide value |
| pinN | input | 2 | Parallel output divide code |
| parLoadN | input | 1 | Parallel-load control; low = pins flow through, rising = capture |
| serClk | input | 1 | Serial shift clock (asynchronous) |
| serData | input | 1 | Serial data, sampled on serClk rising |
| serStrobe | input | 1 | Serial load strobe; rise = transfer, high = pass-through, fall = freeze |
| activeM | output | 9 | Active feedback divide value |
| activeN | output | 2 | Active output divide code |
| activeT | output | 2 | Active test-select field, 0 in parallel mode |
| shiftTap | output | 1 | Last bit shifted into the shift register |

## Verification
A shift register holding a wrong value stays hidden at first: it reaches the ports only at the next strobe rise or pass-through shift. The shiftTap output does expose its newest bit one cycle after each shift. A wrong edge detection or a wrong synchronizer depth shifts every update by whole cycles, so comparing with a reference on every cycle exposes it at the first serial edge or mode change. A lost hold, such as an active register that reloads from the pins while in serial mode, shows on activeM within one cycle of the next pin change.

// File: rtl/divcfg_pkg.sv
package divcfg_pkg;
  localparam int M_W = 9;
  localparam int N_W = 2;
  localparam int T_W = 2;
  localparam int WORD_W = M_W + N_W + T_W;

  // Strobes from the control side to the datapath, valid for one system clock each
  typedef struct packed {
    logic shiftEn;   // qualified serial clock rise: shift one bit
    logic takeSer;   // strobe high in serial mode: active <= shift contents
    logic takePins;  // parallel flow or parallel capture: active <= pins
    logic testOn;    // synchronized parallel-load control is high
  } ctrlStrb_t;
endpackage

// File: rtl/divcfg_ctrl.sv
module divcfg_ctrl
  import divcfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      parLoadN,
  input  logic      serClk,
  input  logic      serData,
  input  logic      serStrobe,
  output ctrlStrb_t strb,
  output logic      serBit
);
  localparam int LINES  = 4;
  localparam int LN_STB = 0;
  localparam int LN_DAT = 1;
  localparam int LN_CLK = 2;
  localparam int LN_PAR = 3;

  logic [LINES-1:0] rawIn;
  logic [LINES-1:0] syncVec;
  logic parDly, clkDly;
  logic parRise, clkRise;

  assign rawIn = {parLoadN, serClk, serData, serStrobe};

  // Each asynchronous control gets its own flop chain, all with equal depth
  // so data and clock stay aligned after synchronization.
  for (genvar g = 0; g < LINES; g++) begin : gSync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[SYNC_STAGES-2:0], rawIn[g]};
    end
    assign syncVec[g] = chain[SYNC_STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      parDly <= 1'b0;
      clkDly <= 1'b0;
    end else begin
      parDly <= syncVec[LN_PAR];
      clkDly <= syncVec[LN_CLK];
    end
  end

  assign parRise = syncVec[LN_PAR] & ~parDly;
  assign clkRise = syncVec[LN_CLK] & ~clkDly;

  always_comb begin
    strb.takePins = ~syncVec[LN_PAR] | parRise;
    strb.shiftEn  = syncVec[LN_PAR] & clkRise;
    strb.takeSer  = syncVec[LN_PAR] & ~parRise & syncVec[LN_STB];
    strb.testOn   = syncVec[LN_PAR];
  end

  assign serBit = syncVec[LN_DAT];

  // R3: a serial shift pulse lasts one cycle per serial clock rise
  assert_single_shift_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.shiftEn |=> !strb.shiftEn);
endmodule

// File: rtl/divcfg_dpath.sv
module divcfg_dpath
  import divcfg_pkg::*;
#(
  parameter int MW = M_W,
  parameter int NW = N_W,
  parameter int TW = T_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrb_t     strb,
  input  logic          serBit,
  input  logic [MW-1:0] pinM,
  input  logic [NW-1:0] pinN,
  output logic [MW-1:0] mOut,
  output logic [NW-1:0] nOut,
  output logic [TW-1:0] tOut,
  output logic          shiftTap
);
  localparam int WW = MW + NW + TW;

  logic [WW-1:0] shReg, shNext;
  logic [MW-1:0] mReg;
  logic [NW-1:0] nReg;
  logic [TW-1:0] tReg;

  // MSB-first: after a full word, the test bits sit at the top, M0 at the bottom
  assign shNext = strb.shiftEn ? {shReg[WW-2:0], serBit} : shReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg <= '0;
      mReg  <= pinM;
      nReg  <= pinN;
      tReg  <= '0;
    end else begin
      shReg <= shNext;
      if (strb.takePins) begin
        mReg <= pinM;
        nReg <= pinN;
      end else if (strb.takeSer) begin
        {tReg, nReg, mReg} <= shNext;
      end
    end
  end

  assign mOut     = mReg;
  assign nOut     = nReg;
  assign tOut     = strb.testOn ? tReg : '0;
  assign shiftTap = shReg[0];

  // R1: pin path loads the active fields on the following edge
  assert_pin_load_R1: assert property (@(posedge clk) disable iff (!rstN)
    strb.takePins |=> (mReg == $past(pinM)) && (nReg == $past(pinN)));

  // R7: with no load strobe of any kind the active word holds
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.takePins && !strb.takeSer) |=> $stable(mReg) && $stable(nReg) && $stable(tReg));

  // R8: test-select changes only through the serial transfer
  assert_test_serial_only_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.takeSer |=> $stable(tReg));

  // R3: tap shows the bit that was just shifted
  assert_tap_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.shiftEn |=> shiftTap == $past(serBit));
endmodule

// File: rtl/divcfg_loader.sv
module divcfg_loader
  import divcfg_pkg::*;
#(
  parameter int MW = M_W,
  parameter int NW = N_W,
  parameter int TW = T_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [MW-1:0] pinM,
  input  logic [NW-1:0] pinN,
  input  logic          parLoadN,
  input  logic          serClk,
  input  logic          serData,
  input  logic          serStrobe,
  output logic [MW-1:0] activeM,
  output logic [NW-1:0] activeN,
  output logic [TW-1:0] activeT,
  output logic          shiftTap
);
  ctrlStrb_t strb;
  logic      serBit;

  divcfg_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .parLoadN(parLoadN), .serClk(serClk),
    .serData(serData), .serStrobe(serStrobe), .strb(strb), .serBit(serBit)
  );

  divcfg_dpath #(.MW(MW), .NW(NW), .TW(TW)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .serBit(serBit), .pinM(pinM), .pinN(pinN),
    .mOut(activeM), .nOut(activeN), .tOut(activeT), .shiftTap(shiftTap)
  );

  // R8: test field reads zero once a low parallel-load level has crossed the synchronizer
  assert_test_forced_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$past(parLoadN, SYNC_STAGES) |-> activeT == '0);
endmodule

// File: tb/tb_divcfg_loader.sv
module tb_divcfg_loader;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [8:0] pinM = 9'h1A5;
  logic [1:0] pinN = 2'd2;
  logic       parLoadN = 1'b0;
  logic       serClk = 1'b0;
  logic       serData = 1'b0;
  logic       serStrobe = 1'b0;
  logic [8:0] activeM;
  logic [1:0] activeN;
  logic [1:0] activeT;
  logic       shiftTap;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  divcfg_loader dut (
    .clk(clk), .rstN(rstN), .pinM(pinM), .pinN(pinN), .parLoadN(parLoadN),
    .serClk(serClk), .serData(serData), .serStrobe(serStrobe),
    .activeM(activeM), .activeN(activeN), .activeT(activeT), .shiftTap(shiftTap)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------- behavioural reference, advanced on every rising edge ----------
  bit [3:0]  hq[$];          // input samples, newest first: {par, sclk, sdat, strobe}
  int        refM, refN, refT, refSh, refParLvl;
  bit        refValid = 0;

  always @(posedge clk) begin
    hq.push_front({parLoadN, serClk, serData, serStrobe});
    if (!rstN) begin
      hq = '{4'b0, 4'b0, 4'b0, 4'b0};
      refM = pinM; refN = pinN; refT = 0; refSh = 0;
      refValid = 1;
    end else begin
      bit [3:0] cur, prv;
      bit parRise, clkRise;
      cur = hq[2];
      prv = hq[3];
      parRise = cur[3] && !prv[3];
      clkRise = cur[2] && !prv[2];
      if (cur[3] && clkRise) refSh = ((refSh << 1) | cur[1]) & 13'h1FFF;
      if (!cur[3] || parRise) begin
        refM = pinM; refN = pinN;
      end else if (cur[0]) begin
        refM = refSh & 9'h1FF;
        refN = (refSh >> 9) & 3;
        refT = (refSh >> 11) & 3;
      end
      void'(hq.pop_back());
    end
    refParLvl = hq[1][3];
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (refValid && !done) begin
      chk("model R1 R4 R6 activeM", int'(activeM), refM);
      chk("model R2 R5 activeN", int'(activeN), refN);
      chk("model R8 activeT", int'(activeT), refParLvl ? refT : 0);
      chk("model R3 shiftTap", int'(shiftTap), refSh & 1);
    end
  end

  // ---------- stimulus helpers ----------
  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(bit b);
    @(negedge clk); serData = b;
    waitN(2); serClk = 1'b1;
    waitN(3); serClk = 1'b0;
    waitN(3);
  endtask

  task automatic sendWord(bit [12:0] w);
    for (int i = 12; i >= 0; i--) sendBit(w[i]);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit [12:0] w;
    bit [1:0]  keptT;
    logic [8:0] snapM;
    waitN(3);
    // R9: reset state
    chk("R9 reset activeM", int'(activeM), 'h1A5);
    chk("R9 reset activeN", int'(activeN), 2);
    chk("R9 reset activeT", int'(activeT), 0);
    chk("R9 reset shiftTap", int'(shiftTap), 0);
    rstN = 1'b1;
    waitN(4);

    // R1: parallel flow
    pinM = 9'h019; pinN = 2'd1;
    waitN(1);
    chk("R1 flow activeM", int'(activeM), 'h019);
    chk("R1 flow activeN", int'(activeN), 1);

    // R2: capture on rise, ignore later pins
    parLoadN = 1'b1;
    waitN(5);
    pinM = 9'h0FF; pinN = 2'd0;
    waitN(4);
    chk("R2 held activeM", int'(activeM), 'h019);
    chk("R2 held activeN", int'(activeN), 1);

    // R3: shift word A = T 10, N 11, M 11C; strobe low so no change (R5/R7)
    sendWord(13'h171C);
    chk("R3 tap last bit", int'(shiftTap), 0);
    chk("R7 no transfer activeM", int'(activeM), 'h019);

    // R4: strobe rise transfers
    @(negedge clk); serStrobe = 1'b1;
    waitN(5);
    chk("R4 transfer activeM", int'(activeM), 'h11C);
    chk("R4 transfer activeN", int'(activeN), 3);
    chk("R4 transfer activeT", int'(activeT), 2);
    serStrobe = 1'b0;
    waitN(5);

    // R5: shift word B = T 01, N 00, M 0A7 with strobe low; active frozen
    sendWord(13'h08A7);
    chk("R5 frozen activeM", int'(activeM), 'h11C);
    chk("R5 frozen activeT", int'(activeT), 2);
    chk("R3 tap after B", int'(shiftTap), 1);

    // R7: idle
    snapM = activeM;
    waitN(20);
    chk("R7 idle activeM", int'(activeM), int'(snapM));

    // R6: strobe held high passes through
    @(negedge clk); serStrobe = 1'b1;
    waitN(5);
    chk("R6 enter activeM", int'(activeM), 'h0A7);
    chk("R6 enter activeT", int'(activeT), 1);
    w = 13'h08A7;
    for (int k = 0; k < 3; k++) begin
      bit b;
      b = (k != 1);
      sendBit(b);
      w = {w[11:0], b};
      chk("R6 pass activeM", int'(activeM), int'(w[8:0]));
      chk("R6 pass activeN", int'(activeN), int'(w[10:9]));
      chk("R6 pass activeT", int'(activeT), int'(w[12:11]));
    end
    keptT = w[12:11];
    serStrobe = 1'b0;
    waitN(5);
    sendBit(1'b1);
    chk("R5 after fall activeM", int'(activeM), int'(w[8:0]));

    // R8: parallel mode hides T; parallel capture keeps it
    parLoadN = 1'b0;
    waitN(4);
    chk("R8 forced low activeT", int'(activeT), 0);
    chk("R1 reflow activeM", int'(activeM), 'h0FF);
    pinM = 9'h033; pinN = 2'd3;
    waitN(2);
    chk("R1 new pins activeM", int'(activeM), 'h033);
    parLoadN = 1'b1;
    waitN(5);
    chk("R8 kept activeT", int'(activeT), int'(keptT));
    chk("R2 capture activeN", int'(activeN), 3);

    done = 1;
    waitN(2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule